// File: doc/BRIEF.md
# Scoreboarded Switch-Port Output Queue

This block is the egress side of one port in a packet crossbar. Packets arrive from the other ports' address decoders as streams of 16-bit symbols with start and end flags. Each packet is sorted by its class into one of two independent queues, one for requests and one for responses. Each queue publishes a single scoreboard bit. A decoder elsewhere reads that bit and hands over a new packet only while it is clear. The bit sets on the cycle after a packet is admitted. It clears only when no packet is being received and the queue has room for one more packet of the largest allowed size. Broadcast packets are admitted at most once per broadcast sequence tag. A per-class reserve input can hold a queue for a pending broadcast by turning away unicast traffic.

On the output side, only complete packets are offered. At a packet boundary a waiting response goes ahead of a waiting request. No new packet starts while the port's bypass path is sending. A packet that has started runs to its end without interruption.

Ingress back-pressure: `in_ready` is meaningful on every symbol. For a start symbol it carries the admission decision. If the start symbol is refused, the sender withdraws it (a retry is signalled elsewhere) and is not required to hold it. Once a start symbol is taken, `in_ready` stays high for the rest of that packet. Egress follows plain valid/ready: a symbol moves when `out_valid` and `out_ready` are both high, and the presented symbol is held until taken.

Top module: `sbq_port_egress`

## Requirements
- R1: After reset both queues are empty, `out_valid` is 0, `sb_busy` and `bc_taken` are 0, and `in_ready` is 1.
- R2: `in_class` 0 selects the request queue and 1 selects the response queue. Each queue returns its own symbols in arrival order, with the data, `out_sop` and `out_eop` unchanged, and `out_class` names the queue.
- R3: `sb_busy[c]` is 1 on the cycle after a start symbol of class c is admitted, and stays 1 while that packet is being received. While it is 1, a start symbol of class c sees `in_ready` 0.
- R4: `sb_busy[c]` returns to 0 one cycle after the last symbol is written, if the free entries of queue c are then at least MAX_PKT. Otherwise it stays 1 until draining frees that much room.
- R5: While `bypass_busy` is 1 and no packet is part-way out, `out_valid` is 0. When `bypass_busy` falls, a waiting packet is offered on the next cycle.
- R6: Only packets whose end symbol is stored are offered. At a packet boundary a waiting response packet is offered before a waiting request packet.
- R7: Once the first symbol of a packet has left, the following symbols come from the same queue with `out_sop` 0 until its end symbol. `bypass_busy` does not pause it.
- R8: Admitting a broadcast (`in_bcast` 1) sets `bc_taken[c]` and records `in_tag`. A later broadcast start of class c with the same tag is refused. A broadcast start with a different tag clears `bc_taken[c]` and is admitted if `sb_busy[c]` is 0.
- R9: While `rsv_req[c]` is 1, unicast start symbols of class c are refused, but broadcast start symbols of class c are still admitted.
- R10: A symbol with `in_sop` 0 that arrives outside any packet is taken (`in_ready` 1) and discarded. Nothing is stored and the scoreboard bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress symbol valid |
| in_ready | output | 1 | Ingress symbol taken / admission decision at start |
| in_data | input | 16 | Ingress symbol payload |
| in_sop | input | 1 | First symbol of a packet |
| in_eop | input | 1 | Last symbol of a packet |
| in_class | input | 1 | 0 request, 1 response (sampled at start) |
| in_bcast | input | 1 | Packet is a broadcast (sampled at start) |
| in_tag | input | 4 | Broadcast sequence tag (sampled at start) |
| rsv_req | input | 2 | Per-class hold for a pending broadcast |
| bypass_busy | input | 1 | Bypass path is sending; blocks a new packet start |
| out_valid | output | 1 | Egress symbol valid |
| out_ready | input | 1 | Link accepts the egress symbol |
| out_data | output | 16 | Egress symbol payload |
| out_sop | output | 1 | Egress first symbol |
| out_eop | output | 1 | Egress last symbol |
| out_class | output | 1 | Queue the egress symbol comes from |
| sb_busy | output | 2 | Scoreboard bit per class |
| bc_taken | output | 2 | Broadcast-accepted bit per class |

## Verification
A scoreboard bit stuck at 1 turns away every later start symbol of its class on the next attempt. A bit that clears too early lets a packet in with too little room, so stored symbols are lost and show up as missing or reordered payload at the egress. A wrong broadcast flag or tag shows at once as a second admission, or as a wrong refusal of a fresh tag. A lost egress lock or a wrong class choice shows within one packet as a split packet, a stray `out_sop`, or a request leaving ahead of a waiting response.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  localparam int SYM_DATA_W = 16;
  localparam int NUM_CLASS  = 2;
  localparam int CLS_REQ    = 0;
  localparam int CLS_RSP    = 1;

  typedef struct packed {
    logic                  sop;
    logic                  eop;
    logic [SYM_DATA_W-1:0] data;
  } sym_t;
endpackage

// File: rtl/sbq_queue.sv
module sbq_queue
  import sbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  sym_t          wr_sym,
  input  logic          rd_en,
  output sym_t          rd_sym,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] whole_pkts,
  output logic          is_empty
);
  sym_t          store [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q, pkts_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) store[wp_q] <= wr_sym;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
      pkts_q <= '0;
    end else begin
      if (wr_en) wp_q <= bump(wp_q);
      if (rd_en) rp_q <= bump(rp_q);
      fill_q <= fill_q + CW'(wr_en) - CW'(rd_en);
      pkts_q <= pkts_q + CW'(wr_en && wr_sym.eop) - CW'(rd_en && store[rp_q].eop);
    end
  end

  assign rd_sym     = store[rp_q];
  assign fill       = fill_q;
  assign whole_pkts = pkts_q;
  assign is_empty   = (fill_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fill_q < CW'(DEPTH)));  // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (fill_q != '0));  // R7
endmodule

// File: rtl/sbq_admit.sv
module sbq_admit #(
  parameter int DEPTH   = 8,
  parameter int MAX_PKT = 4,
  parameter int TAG_W   = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_seen,
  input  logic             bcast,
  input  logic [TAG_W-1:0] tag,
  input  logic             hold,
  input  logic             admit,
  input  logic             receiving,
  input  logic [CW-1:0]    fill,
  output logic             busy,
  output logic             taken,
  output logic             may_admit
);
  logic             busy_q, taken_q;
  logic [TAG_W-1:0] tag_q;
  logic [CW-1:0]    room;
  logic             same_tag;

  assign room     = CW'(DEPTH) - fill;
  assign same_tag = (tag == tag_q);

  always_comb begin
    if (busy_q)     may_admit = 1'b0;
    else if (bcast) may_admit = !(taken_q && same_tag);
    else            may_admit = !hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      taken_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      if (admit)
        busy_q <= 1'b1;
      else if (busy_q && !receiving && room >= CW'(MAX_PKT))
        busy_q <= 1'b0;

      if (admit && bcast) begin
        taken_q <= 1'b1;
        tag_q   <= tag;
      end else if (start_seen && bcast && !same_tag) begin
        taken_q <= 1'b0;
      end
    end
  end

  assign busy  = busy_q;
  assign taken = taken_q;

  AST_BUSY_ON_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
    admit |=> busy_q);  // R3
  AST_BUSY_WHILE_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !admit && room < CW'(MAX_PKT)) |=> busy_q);  // R4
  AST_BCAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && bcast && taken_q && same_tag) |-> !admit);  // R8
  AST_HOLD_BLOCKS_UNICAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !bcast && hold) |-> !admit);  // R9
endmodule

// File: rtl/sbq_egress_arb.sv
module sbq_egress_arb
  import sbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        pkts_req,
  input  logic [CW-1:0]        pkts_rsp,
  input  logic [NUM_CLASS-1:0] q_empty,
  input  sym_t                 head_req,
  input  sym_t                 head_rsp,
  input  logic                 bypass_busy,
  input  logic                 out_ready,
  output logic                 out_valid,
  output sym_t                 out_sym,
  output logic                 out_cls,
  output logic [NUM_CLASS-1:0] rd_en
);
  logic lock_q, lock_cls_q;
  logic fire;
  logic rsp_waiting, req_waiting;

  assign rsp_waiting = (pkts_rsp != '0);
  assign req_waiting = (pkts_req != '0);

  always_comb begin
    if (lock_q) begin
      out_cls   = lock_cls_q;
      out_valid = !q_empty[lock_cls_q];
    end else begin
      out_cls   = rsp_waiting;
      out_valid = !bypass_busy && (rsp_waiting || req_waiting);
    end
    out_sym = out_cls ? head_rsp : head_req;
  end

  assign fire  = out_valid && out_ready;
  assign rd_en = {fire && out_cls, fire && !out_cls};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_cls_q <= 1'b0;
    end else if (fire) begin
      lock_q     <= !out_sym.eop;
      lock_cls_q <= out_cls;
    end
  end

  AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_sym.eop) |=> (out_valid && !out_sym.sop && out_cls == $past(out_cls)));  // R7
  AST_BYPASS_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_busy && out_valid) |-> !out_sym.sop);  // R5
  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sym.sop && rsp_waiting) |-> out_cls);  // R6
  AST_WHOLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sym.sop) |-> (out_cls ? rsp_waiting : req_waiting));  // R6
endmodule

// File: rtl/sbq_port_egress.sv
module sbq_port_egress
  import sbq_pkg::*;
#(
  parameter int MAX_PKT = 4,
  parameter int QDEPTH  = 8,
  parameter int TAG_W   = 4,
  localparam int DW = SYM_DATA_W,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_class,
  input  logic             in_bcast,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [1:0]       rsv_req,
  input  logic             bypass_busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_class,
  output logic [1:0]       sb_busy,
  output logic [1:0]       bc_taken
);
  logic                 rx_active_q, rx_cls_q;
  logic                 in_fire;
  logic [NUM_CLASS-1:0] may_admit, admit, wr_en, rd_en, q_empty, start_seen, receiving;
  logic [CW-1:0]        fill   [NUM_CLASS];
  logic [CW-1:0]        wpkts  [NUM_CLASS];
  sym_t                 head   [NUM_CLASS];
  sym_t                 in_sym, out_sym;

  assign in_sym = '{sop: in_sop, eop: in_eop, data: in_data};

  always_comb begin
    if (rx_active_q) in_ready = 1'b1;
    else if (in_sop) in_ready = may_admit[in_class];
    else             in_ready = 1'b1;
  end

  assign in_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_active_q <= 1'b0;
      rx_cls_q    <= 1'b0;
    end else if (in_fire) begin
      if (!rx_active_q && in_sop && !in_eop) begin
        rx_active_q <= 1'b1;
        rx_cls_q    <= in_class;
      end else if (rx_active_q && in_eop) begin
        rx_active_q <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    assign start_seen[c] = in_valid && in_sop && !rx_active_q && (in_class == 1'(c));
    assign admit[c]      = start_seen[c] && in_ready;
    assign receiving[c]  = rx_active_q && (rx_cls_q == 1'(c));
    assign wr_en[c]      = in_fire && (receiving[c] || admit[c]);

    sbq_queue #(.DEPTH(QDEPTH)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en[c]),
      .wr_sym     (in_sym),
      .rd_en      (rd_en[c]),
      .rd_sym     (head[c]),
      .fill       (fill[c]),
      .whole_pkts (wpkts[c]),
      .is_empty   (q_empty[c])
    );

    sbq_admit #(.DEPTH(QDEPTH), .MAX_PKT(MAX_PKT), .TAG_W(TAG_W)) u_adm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_seen (start_seen[c]),
      .bcast      (in_bcast),
      .tag        (in_tag),
      .hold       (rsv_req[c]),
      .admit      (admit[c]),
      .receiving  (receiving[c]),
      .fill       (fill[c]),
      .busy       (sb_busy[c]),
      .taken      (bc_taken[c]),
      .may_admit  (may_admit[c])
    );
  end

  sbq_egress_arb #(.DEPTH(QDEPTH)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkts_req    (wpkts[CLS_REQ]),
    .pkts_rsp    (wpkts[CLS_RSP]),
    .q_empty     (q_empty),
    .head_req    (head[CLS_REQ]),
    .head_rsp    (head[CLS_RSP]),
    .bypass_busy (bypass_busy),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_sym     (out_sym),
    .out_cls     (out_class),
    .rd_en       (rd_en)
  );

  assign out_data = out_sym.data;
  assign out_sop  = out_sym.sop;
  assign out_eop  = out_sym.eop;

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !rx_active_q && sb_busy[in_class]) |-> !in_ready);  // R3
  AST_MID_PKT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active_q |-> in_ready);  // R3
  AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && !rx_active_q) |-> (wr_en == '0));  // R10
endmodule

// File: tb/sbq_port_egress_tb.sv
module sbq_port_egress_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sop, in_eop, in_class, in_bcast;
  logic [15:0] in_data;
  logic [3:0]  in_tag;
  logic [1:0]  rsv_req;
  logic        bypass_busy;
  logic        out_valid, out_ready, out_sop, out_eop, out_class;
  logic [15:0] out_data;
  logic [1:0]  sb_busy, bc_taken;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [17:0] exp_q [2][$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbq_port_egress #(.MAX_PKT(4), .QDEPTH(8), .TAG_W(4)) u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
    .in_class, .in_bcast, .in_tag, .rsv_req, .bypass_busy,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop, .out_class,
    .sb_busy, .bc_taken
  );

  typedef struct packed {
    logic        op;     // 0 send, 1 drain
    logic        cls;
    logic        bc;
    logic [3:0]  tag;
    logic [3:0]  len;
    logic [15:0] base;
    logic        acc;
    logic        busy;
    logic        taken;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 16'd10, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd0, 4'd2, 16'd20, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 16'd30, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd1, 16'd40, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 4'd1, 4'd2, 16'd50, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'd1, 4'd2, 16'd60, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 4'd2, 4'd2, 16'd70, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'd2, 4'd4, 16'd80, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 4'd2, 4'd1, 16'd90, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 16'd0,  1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a negedge; returns at a negedge after the last symbol was taken.
  task automatic send(input logic cls, input logic bc, input logic [3:0] tag,
                      input int len, input logic [15:0] base, input bit record,
                      output bit acc);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_class = cls;
      in_bcast = bc;
      in_tag   = tag;
      in_data  = base + 16'(i);
      #1;
      if (i == 0 && !in_ready) begin
        acc = 1'b0;
        in_valid = 1'b0;
        return;
      end
      if (i != 0) check("R3 ready mid-packet", in_ready, 1);
      if (record) exp_q[cls].push_back({in_sop, in_eop, in_data});
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    acc = 1'b1;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int k = 0; k < 200; k++) begin
      #1;
      if (exp_q[0].size() == 0 && exp_q[1].size() == 0) break;
      if (out_valid) begin
        if (out_sop && exp_q[1].size() != 0)
          check("R6 response first", out_class, 1);
        if (exp_q[out_class].size() == 0) begin
          check("R2 unexpected symbol", 1, 0);
        end else begin
          check("R2 symbol", {out_sop, out_eop, out_data}, exp_q[out_class].pop_front());
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    check("R2 all drained", exp_q[0].size() + exp_q[1].size(), 0);
    out_ready = 1'b0;
    idle(2);
    check("R2 nothing left", out_valid, 0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit acc;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_class = 1'b0;
    in_bcast = 1'b0; in_tag = '0; in_data = '0; rsv_req = '0; bypass_busy = 1'b0;
    out_ready = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 sb_busy", sb_busy, 0);
    check("R1 bc_taken", bc_taken, 0);
    check("R1 in_ready", in_ready, 1);
    @(negedge clk);

    // Vector walk: R2 R3 R4 R6 R8
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].op) begin
        drain();
      end else begin
        send(VEC[v].cls, VEC[v].bc, VEC[v].tag, int'(VEC[v].len), VEC[v].base, 1'b1, acc);
        check($sformatf("R3/R8/R9 admit v%0d", v), acc, VEC[v].acc);
        idle(3);
      end
      check($sformatf("R4 busy v%0d", v), sb_busy[VEC[v].cls], VEC[v].busy);
      check($sformatf("R8 taken v%0d", v), bc_taken[VEC[v].cls], VEC[v].taken);
    end

    // R3 / R4: busy timing and refusal
    send(1'b0, 1'b0, 4'd0, 4, 16'd200, 1'b1, acc);
    check("R3 busy after packet", sb_busy[0], 1);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_class = 1'b0; in_bcast = 1'b0;
    #1;
    check("R3 busy refuses start", in_ready, 0);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 busy cleared with room", sb_busy[0], 0);
    drain();

    // R5: bypass blocks a new start
    bypass_busy = 1'b1;
    send(1'b0, 1'b0, 4'd0, 2, 16'd100, 1'b1, acc);
    out_ready = 1'b1;
    idle(2);
    #1;
    check("R5 blocked by bypass", out_valid, 0);
    out_ready = 1'b0;
    bypass_busy = 1'b0;
    @(negedge clk);
    #1;
    check("R5 offered after bypass", out_valid && out_sop, 1);
    @(negedge clk);
    drain();

    // R7: started packet is not split by bypass
    send(1'b0, 1'b0, 4'd0, 3, 16'd110, 1'b0, acc);
    out_ready = 1'b1;
    #1;
    check("R7 first symbol", out_sop ? 32'(out_data) : 0, 110);
    @(posedge clk); @(negedge clk);
    bypass_busy = 1'b1;
    #1;
    check("R7 continues under bypass", {out_valid, out_sop, out_data}, {2'b10, 16'd111});
    @(posedge clk); @(negedge clk);
    #1;
    check("R7 last symbol", {out_valid, out_eop, out_data}, {2'b11, 16'd112});
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    bypass_busy = 1'b0;
    idle(1);

    // R10: stray symbol outside a packet
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_class = 1'b1; in_data = 16'hBEEF;
    #1;
    check("R10 stray taken", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    idle(3);
    check("R10 nothing stored", out_valid, 0);
    check("R10 scoreboard unchanged", sb_busy, 0);

    // R9: reserve holds request queue for a broadcast
    rsv_req = 2'b01;
    send(1'b0, 1'b0, 4'd0, 2, 16'd300, 1'b1, acc);
    check("R9 unicast refused", acc, 0);
    idle(1);
    send(1'b0, 1'b1, 4'd5, 2, 16'd310, 1'b1, acc);
    check("R9 broadcast admitted", acc, 1);
    idle(3);
    send(1'b1, 1'b0, 4'd0, 1, 16'd320, 1'b1, acc);
    check("R9 other class unaffected", acc, 1);
    rsv_req = 2'b00;
    idle(3);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule